// File: doc/BRIEF.md
# Redundant Parameter Table Majority Decoder

This block rebuilds a small table of read-retry parameters from a byte buffer that was copied out of a one-time-programmable flash area. Every item in that area is stored several times, so a single corrupted byte does not lose the item. The table entries are also stored a second time with every bit inverted. The block first reads the copies of the two header counts, which are the number of modes and the number of registers per mode. It then walks the table one entry at a time, reads all the copies of the entry and accepts a value only when a strict majority of the copies agree on it.

When the plain copies of an entry give no clear winner, the block votes the bit-inverted copies instead and complements the winner before storing it. Each accepted entry leaves the block as one write on a table port, addressed by its flat index `mode*nregs + reg`. A successful decode ends with a single-cycle `done` pulse. Any vote that cannot be resolved ends the decode with a single-cycle `error` pulse instead. The buffer sits outside the block and is read through a port with one cycle of read latency.

Top module: `otp_vote_decoder`

## Requirements
- R1: After reset, `done`, `error` and `tbl_we` are low, and `nmodes` and `nregs` read zero.
- R2: Buffer bytes 0..7 hold eight copies of the mode count and bytes 8..15 hold eight copies of the register count. Each count is resolved by vote and, once resolved, is held on `nmodes` or `nregs`.
- R3: The table size is S = nmodes*nregs. The plain copy k of entry e is read from byte 16 + 2k*S + e, and the inverted copy k is read from byte 16 + (2k+1)*S + e, for k = 0..7. `rd_data` returns the byte addressed by `rd_addr` one clock later.
- R4: A vote considers the copies at positions 0..3 in ascending order, where position k is copy k. A candidate wins when strictly more than 4 of the copies after it hold an equal value. Six equal copies at positions 2..7 are accepted. Five equal copies at positions 0..4, with the other three differing, are rejected.
- R5: If the plain copies of an entry have no winner, the inverted copies are voted, and the bitwise complement of their winner is written to the table.
- R6: If neither the plain nor the inverted copies of an entry produce a winner, the decode stops with an `error` pulse and writes no further entries.
- R7: If either header vote fails, the decode stops with an `error` pulse and makes no table write.
- R8: Entries are written in ascending flat index 0..S-1, each with exactly one `tbl_we` cycle and `tbl_addr` equal to the index. After the last write, `done` pulses.
- R9: If S is zero, the decode ends with `done` and makes no table write.
- R10: If S exceeds the table depth (2^TBL_AW entries), the decode ends with `error` and makes no table write.
- R11: Each decode started by `start` ends with exactly one single-cycle pulse, either `done` or `error`. The two are never high together, and neither is high together with `tbl_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a decode when the block is idle |
| rd_addr | output | ADDR_W | Registered byte address into the buffer |
| rd_data | input | 8 | Buffer byte for the previous cycle's `rd_addr` |
| nmodes | output | 8 | Resolved mode count |
| nregs | output | 8 | Resolved register count |
| tbl_we | output | 1 | Table write strobe |
| tbl_addr | output | TBL_AW | Flat table index mode*nregs+reg |
| tbl_data | output | 8 | Recovered entry value |
| done | output | 1 | Successful completion pulse |
| error | output | 1 | Failed completion pulse |

## Verification
Each vote round takes eight address cycles, then two more cycles of read and capture latency, then one vote cycle. The time to the first table write or to the end pulse therefore depends on the number of rounds, which varies with the fallback path each entry takes. For this reason the bench does not predict exact cycle numbers. Instead it samples `tbl_we`, `done` and `error` on every falling edge and records each write with its address and order. Once the end pulse has been seen, it compares the recorded writes, the pulse counts and the count outputs with values it computed itself from the buffer image it built.

// File: rtl/otp_vote_pkg.sv
package otp_vote_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_WAIT,
    S_VOTE,
    S_SIZE,
    S_FIN
  } dec_state_t;

  typedef enum logic [1:0] {
    P_MODES,
    P_REGS,
    P_ENTRY
  } dec_phase_t;
endpackage

// File: rtl/copy_gather.sv
module copy_gather #(
  parameter int REPEAT = 8,
  parameter int W      = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         valid,
  input  logic [W-1:0]                 din,
  output logic [REPEAT-1:0][W-1:0]     copies,
  output logic                         full
);
  localparam int CW = $clog2(REPEAT);

  logic [CW-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx    <= '0;
      full   <= 1'b0;
      copies <= '0;
    end else begin
      full <= 1'b0;
      if (valid) begin
        copies[idx] <= din;
        if (idx == CW'(REPEAT - 1)) begin
          idx  <= '0;
          full <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/copy_vote.sv
module copy_vote #(
  parameter int REPEAT = 8,
  parameter int W      = 8
) (
  input  logic [REPEAT-1:0][W-1:0] copies,
  output logic                     ok,
  output logic [W-1:0]             val
);
  localparam int HALF = REPEAT / 2;

  int cnt;

  always_comb begin
    ok  = 1'b0;
    val = '0;
    cnt = 0;
    // descending scan so that the lowest accepted candidate is kept last
    for (int i = HALF - 1; i >= 0; i--) begin
      cnt = 0;
      for (int j = i + 1; j < REPEAT; j++) begin
        if (copies[j] == copies[i]) cnt = cnt + 1;
      end
      if (cnt > HALF) begin
        ok  = 1'b1;
        val = copies[i];
      end
    end
  end
endmodule

// File: rtl/otp_vote_decoder.sv
module otp_vote_decoder
  import otp_vote_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int TBL_AW = 6,
  parameter int REPEAT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic [7:0]        nmodes,
  output logic [7:0]        nregs,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_addr,
  output logic [7:0]        tbl_data,
  output logic              done,
  output logic              error
);
  localparam int CW        = $clog2(REPEAT);
  localparam int HALF      = REPEAT / 2;
  localparam int TBL_DEPTH = 1 << TBL_AW;
  localparam int HDR_BYTES = 2 * REPEAT;

  dec_state_t              state;
  dec_phase_t              phase;
  logic [CW-1:0]           k;
  logic [ADDR_W-1:0]       addr_acc;
  logic [ADDR_W-1:0]       stride;
  logic                    rd_v;
  logic                    dat_v;
  logic [15:0]             setsize;
  logic [15:0]             ent;
  logic                    inv;
  logic [15:0]             prod;

  logic [REPEAT-1:0][7:0]  copies;
  logic                    full;
  logic                    vote_ok;
  byte_t                   vote_val;

  copy_gather #(.REPEAT(REPEAT), .W(8)) gather_i (
    .clk    (clk),
    .rst    (rst),
    .valid  (dat_v),
    .din    (rd_data),
    .copies (copies),
    .full   (full)
  );

  copy_vote #(.REPEAT(REPEAT), .W(8)) vote_i (
    .copies (copies),
    .ok     (vote_ok),
    .val    (vote_val)
  );

  assign prod = 16'(nmodes) * 16'(nregs);

  function automatic logic [ADDR_W-1:0] entry_base(input logic [15:0] e,
                                                   input logic inv_sel,
                                                   input logic [15:0] ss);
    logic [ADDR_W-1:0] b;
    b = ADDR_W'(HDR_BYTES) + ADDR_W'(e);
    if (inv_sel) b = b + ADDR_W'(ss);
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      phase    <= P_MODES;
      k        <= '0;
      addr_acc <= '0;
      stride   <= '0;
      rd_addr  <= '0;
      rd_v     <= 1'b0;
      dat_v    <= 1'b0;
      setsize  <= '0;
      ent      <= '0;
      inv      <= 1'b0;
      nmodes   <= '0;
      nregs    <= '0;
      tbl_we   <= 1'b0;
      tbl_addr <= '0;
      tbl_data <= '0;
      done     <= 1'b0;
      error    <= 1'b0;
    end else begin
      rd_v   <= 1'b0;
      dat_v  <= rd_v;
      tbl_we <= 1'b0;
      done   <= 1'b0;
      error  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            phase    <= P_MODES;
            nmodes   <= '0;
            nregs    <= '0;
            addr_acc <= '0;
            stride   <= ADDR_W'(1);
            k        <= '0;
            state    <= S_FETCH;
          end
        end
        S_FETCH: begin
          rd_addr  <= addr_acc;
          rd_v     <= 1'b1;
          addr_acc <= addr_acc + stride;
          k        <= k + 1'b1;
          if (k == CW'(REPEAT - 1)) state <= S_WAIT;
        end
        S_WAIT: begin
          if (full) state <= S_VOTE;
        end
        S_VOTE: begin
          case (phase)
            P_MODES: begin
              if (vote_ok) begin
                nmodes   <= vote_val;
                phase    <= P_REGS;
                addr_acc <= ADDR_W'(REPEAT);
                k        <= '0;
                state    <= S_FETCH;
              end else begin
                error <= 1'b1;
                state <= S_IDLE;
              end
            end
            P_REGS: begin
              if (vote_ok) begin
                nregs <= vote_val;
                state <= S_SIZE;
              end else begin
                error <= 1'b1;
                state <= S_IDLE;
              end
            end
            default: begin
              if (vote_ok) begin
                tbl_we   <= 1'b1;
                tbl_addr <= ent[TBL_AW-1:0];
                tbl_data <= inv ? ~vote_val : vote_val;
                if (ent == setsize - 16'd1) begin
                  state <= S_FIN;
                end else begin
                  ent      <= ent + 16'd1;
                  inv      <= 1'b0;
                  addr_acc <= entry_base(ent + 16'd1, 1'b0, setsize);
                  k        <= '0;
                  state    <= S_FETCH;
                end
              end else if (!inv) begin
                inv      <= 1'b1;
                addr_acc <= entry_base(ent, 1'b1, setsize);
                k        <= '0;
                state    <= S_FETCH;
              end else begin
                error <= 1'b1;
                state <= S_IDLE;
              end
            end
          endcase
        end
        S_SIZE: begin
          setsize <= prod;
          if (prod == 16'd0) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (prod > 16'(TBL_DEPTH)) begin
            error <= 1'b1;
            state <= S_IDLE;
          end else begin
            phase    <= P_ENTRY;
            ent      <= '0;
            inv      <= 1'b0;
            stride   <= ADDR_W'({prod, 1'b0});
            addr_acc <= ADDR_W'(HDR_BYTES);
            k        <= '0;
            state    <= S_FETCH;
          end
        end
        S_FIN: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ---------------- assertions ----------------
  logic [REPEAT-1:0] eq_win;
  always_comb begin
    for (int i = 0; i < REPEAT; i++) eq_win[i] = (copies[i] == vote_val);
  end

  a_r11_pulse_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, error, tbl_we}));

  a_r8_addr_in_range: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> ({{(16-TBL_AW){1'b0}}, tbl_addr} < setsize));

  a_r4_vote_strength: assert property (@(posedge clk) disable iff (rst)
    (state == S_VOTE && vote_ok) |-> ($countones(eq_win) >= HALF + 2));

  a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
    full |-> $past(rd_v, 2));

  a_r11_done_then_quiet: assert property (@(posedge clk) disable iff (rst)
    done |=> (!tbl_we && !error));
endmodule

// File: tb/otp_vote_decoder_tb_top.sv
module otp_vote_decoder_tb_top;
  localparam int ADDR_W = 10;
  localparam int TBL_AW = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data = '0;
  logic [7:0]        nmodes, nregs;
  logic              tbl_we;
  logic [TBL_AW-1:0] tbl_addr;
  logic [7:0]        tbl_data;
  logic              done, error;

  always #5 clk = ~clk;

  otp_vote_decoder #(.ADDR_W(ADDR_W), .TBL_AW(TBL_AW), .REPEAT(8)) dut_i (
    .clk(clk), .rst(rst), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
    .nmodes(nmodes), .nregs(nregs), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .done(done), .error(error)
  );

  logic [7:0] mem [0:(1<<ADDR_W)-1];
  always @(posedge clk) rd_data <= mem[rd_addr];

  int nvec = 0;
  int nbad = 0;
  logic [7:0] got [0:63];
  int wr_cnt = 0;
  int ord_bad = 0;
  int done_cnt = 0;
  int err_cnt = 0;
  int seed = 0;

  always @(negedge clk) begin
    if (tbl_we) begin
      if (32'(tbl_addr) != wr_cnt) ord_bad++;
      got[tbl_addr] = tbl_data;
      wr_cnt++;
    end
    if (done) done_cnt++;
    if (error) err_cnt++;
  end

  task automatic check(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] val(input int e);
    return 8'((e * 37 + seed * 11 + 5) & 255);
  endfunction

  // hdr: 0 clean, 1 mode header broken, 2 register header broken
  // ent: 0 clean, 1 mixed patterns by e%4, 2 mixed but last entry unresolvable
  task automatic load(input int nm, input int nr, input int hdr, input int ent);
    int ss;
    int pat;
    logic [7:0] v;
    ss = nm * nr;
    for (int a = 0; a < (1 << ADDR_W); a++) mem[a] = 8'(a * 7 + 3);
    for (int k = 0; k < 8; k++) begin
      mem[k]     = (hdr == 1) ? 8'(k * 3 + 1) : 8'(nm);
      mem[8 + k] = (hdr == 2) ? 8'(k * 5 + 2) : 8'(nr);
    end
    for (int e = 0; e < ss; e++) begin
      v   = val(e);
      pat = (ent == 0) ? 0 : (e % 4);
      if (ent == 2 && e == ss - 1) pat = 4;
      for (int k = 0; k < 8; k++) begin
        logic [7:0] p, q;
        p = v;
        q = v ^ 8'hA5;
        case (pat)
          1: if (k < 2) p = v ^ 8'(k + 1);
          2: begin if (k >= 5) p = v ^ 8'(k + 1); q = ~v; end
          3: begin p = v ^ 8'(k + 1); q = ~v; end
          4: begin p = v ^ 8'(k + 1); q = (~v) ^ 8'(k + 1); end
          default: ;
        endcase
        mem[16 + (2 * k) * ss + e]     = p;
        mem[16 + (2 * k + 1) * ss + e] = q;
      end
    end
  endtask

  task automatic run(output bit timed_out);
    wr_cnt = 0; ord_bad = 0; done_cnt = 0; err_cnt = 0;
    for (int i = 0; i < 64; i++) got[i] = 8'h00;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    timed_out = 1'b1;
    for (int c = 0; c < 6000; c++) begin
      @(posedge clk);
      if (done_cnt + err_cnt > 0) begin timed_out = 1'b0; break; end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic decode_ok(input string tag, input int nm, input int nr, input int ent);
    bit to;
    int tbl_bad;
    load(nm, nr, 0, ent);
    run(to);
    check({tag, " R11 timeout"}, int'(to), 0);
    check({tag, " R11 single end pulse"}, done_cnt * 10 + err_cnt, 10);
    check({tag, " R2 nmodes"}, int'(nmodes), nm);
    check({tag, " R2 nregs"}, int'(nregs), nr);
    check({tag, " R8 write count"}, wr_cnt, nm * nr);
    check({tag, " R8 ascending order"}, ord_bad, 0);
    tbl_bad = 0;
    for (int e = 0; e < nm * nr; e++) if (got[e] !== val(e)) tbl_bad++;
    check({tag, " R3 R4 R5 table contents"}, tbl_bad, 0);
  endtask

  initial begin
    #1900000;
    nbad++;
    $display("FAIL R11 watchdog: got %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    bit to;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 done", int'(done), 0);
    check("R1 error", int'(error), 0);
    check("R1 tbl_we", int'(tbl_we), 0);
    check("R1 nmodes", int'(nmodes), 0);
    check("R1 nregs", int'(nregs), 0);

    // R2 R3 clean table, registered read path (R3)
    seed = 1;
    decode_ok("clean3x4", 3, 4, 0);
    seed = 2;
    decode_ok("clean6x10", 6, 10, 0);

    // R4 R5 sweep with mixed copy patterns
    for (int nm = 1; nm <= 4; nm++) begin
      for (int nr = 1; nr <= 4; nr++) begin
        seed = nm * 5 + nr;
        decode_ok("sweep", nm, nr, 1);
      end
    end

    // R6 last entry unresolvable
    seed = 7;
    load(2, 3, 0, 2);
    run(to);
    check("R6 error pulse", err_cnt, 1);
    check("R6 no done", done_cnt, 0);
    check("R6 writes before failure", wr_cnt, 5);

    // R7 header failures
    load(3, 3, 1, 0);
    run(to);
    check("R7 mode header error", err_cnt, 1);
    check("R7 mode header no writes", wr_cnt, 0);
    load(3, 3, 2, 0);
    run(to);
    check("R7 reg header error", err_cnt, 1);
    check("R7 reg header no writes", wr_cnt, 0);
    check("R7 reg header no done", done_cnt, 0);

    // R9 zero size
    load(0, 5, 0, 0);
    run(to);
    check("R9 zero modes done", done_cnt, 1);
    check("R9 zero modes no writes", wr_cnt, 0);
    load(3, 0, 0, 0);
    run(to);
    check("R9 zero regs done", done_cnt, 1);
    check("R9 zero regs no error", err_cnt, 0);

    // R10 oversize table
    load(9, 8, 0, 0);
    run(to);
    check("R10 oversize error", err_cnt, 1);
    check("R10 oversize no writes", wr_cnt, 0);
    check("R10 oversize no done", done_cnt, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule